// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block holds the eight registers of a floating-point register stack. It also holds the bookkeeping those registers need: a rotating top pointer, a 2-bit tag per physical register, a 16-bit control word and a 16-bit status word. A decoder upstream issues one command per cycle. Each command carries a 4-bit operation code, a 3-bit stack-relative index `i`, a 3-bit condition selector, the three integer flags CF, ZF and PF, and a data word. The commands cover the following: initialise the stack, clear exception flags, load the control word, push an external word, push a copy of ST(i), exchange ST(0) with ST(i), conditionally move ST(i) to ST(0), free a register, free and pop, store ST(0) to ST(i), and store and pop.

Register payloads are opaque words of width `DATA_W`. The block never interprets them. The only check on the data is whether a pushed word is zero, and that sets its tag. Stack overflow and underflow are detected here. When the invalid-operation mask bit in the control word is 1, the masked response applies: the destination is filled with a fixed default pattern and tagged special. When that mask bit is 0, the registers are left untouched and an exception pulse is raised. A combinational read port returns ST(rdIdx) so that the surrounding pipeline can see the data.

Top module: `fstack_ctrl`

## Requirements
- R1: After reset and after INIT (op 1), the outputs are as follows: ctrlWord = 0x037F, statWord = 0x0000, topPtr = 0 and tagWord = 0xFFFF. The tag of physical register p sits at tagWord[2p+1:2p]. Tag values: 0 = valid, 1 = zero, 2 = special, 3 = empty.
- R2: ST(i) is physical register (topPtr + i) mod 8, and rdData shows ST(rdIdx). A push decrements topPtr mod 8. A pop first marks the old ST(0) empty, then increments topPtr mod 8. statWord[13:11] always shows topPtr.
- R3: PUSHD (op 10) pushes cmdData. The new entry's tag is 1 when cmdData is zero and 0 otherwise.
- R4: LOAD (op 3) pushes a copy of ST(i), both value and tag. The index i is taken relative to the top before the push.
- R5: Overflow occurs on op 3 or op 10 when the register that would become the new ST(0) is not empty. Overflow sets status bits 0 (invalid) and 6 (stack fault), and sets bit 9 (C1) to 1. With ctrlWord bit 0 set, the push still happens and the new ST(0) holds the fill pattern (top two bits set, the rest zero) with tag 2.
- R6: Unmasked response (ctrlWord bit 0 clear) on any overflow or underflow: no register, tag or topPtr changes. Status bits 7 (summary) and 15 (busy) are set as well, and excRaised pulses. stackErr pulses on every overflow or underflow, masked or not.
- R7: LOAD when ST(i) is empty is an underflow. Underflow sets bits 0 and 6 with C1 = 0. If the response is masked, the push happens with the fill pattern and tag 2.
- R8: XCHG (op 4) with both sides non-empty swaps values and tags, and clears C1.
- R9: XCHG with one side empty is an underflow. If masked, the non-empty value and tag move to the empty side, and the side that was non-empty receives the fill pattern with tag 2. With both sides empty, both receive the fill pattern if masked.
- R10: CMOV (op 5) copies ST(i) and its tag into ST(0) only when the condition holds. condSel[1:0] selects 0 = CF, 1 = ZF, 2 = CF or ZF, 3 = PF, and condSel[2] inverts the result. A false condition changes nothing.
- R11: CMOV whose condition holds but whose ST(i) is empty is an underflow (C1 = 0). The masked response writes the fill pattern with tag 2 into ST(0).
- R12: FREE (op 6) marks ST(i) empty. FREEP (op 7) frees ST(i) and then pops. STORE (op 8) copies ST(0) and its tag into ST(i). STOREP (op 9) does the same and then pops.
- R13: CLEX (op 2) clears status bits 0 to 7 and bit 15 and keeps the others. LDCW (op 11) loads ctrlWord from cmdData[15:0].
- R14: Every accepted command raises done exactly one cycle later. NOP (op 0) changes nothing. Op codes 12 to 15 raise illegal with done and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 4 | Operation code |
| cmdIdx | input | 3 | Stack-relative index i |
| condSel | input | 3 | Conditional-move condition selector |
| flagCf | input | 1 | Integer carry flag |
| flagZf | input | 1 | Integer zero flag |
| flagPf | input | 1 | Integer parity flag |
| cmdData | input | DATA_W | Word for PUSHD, or control word for LDCW |
| rdIdx | input | 3 | Stack-relative read index |
| rdData | output | DATA_W | Value of ST(rdIdx) |
| topPtr | output | 3 | Current top-of-stack physical index |
| tagWord | output | 16 | Packed tags |
| ctrlWord | output | 16 | Control word |
| statWord | output | 16 | Status word with topPtr in bits 13:11 |
| done | output | 1 | Command completed (one cycle after issue) |
| illegal | output | 1 | Undefined op code was issued |
| stackErr | output | 1 | Overflow or underflow occurred |
| excRaised | output | 1 | Unmasked stack exception |

## Verification
Every result is due one clock edge after the command is issued. The registers, tags, top pointer and status word all update on the same edge that latches the command, and done, illegal, stackErr and excRaised are registered at that same edge. The bench applies a command on a falling edge and holds it for one period. It then samples every output on the next falling edge, which is exactly one rising edge later. rdData is combinational from the state, so the bench sets rdIdx and reads the value after a short settling delay within the same low phase.

// File: rtl/fstack_pkg.sv
package fstack_pkg;

  localparam int NREG  = 8;
  localparam int IDX_W = 3;
  localparam int TAG_W = 2;
  localparam int TW_W  = NREG * TAG_W;

  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_INIT  = 4'd1;
  localparam logic [3:0] OP_CLEX  = 4'd2;
  localparam logic [3:0] OP_LDI   = 4'd3;
  localparam logic [3:0] OP_XCH   = 4'd4;
  localparam logic [3:0] OP_CMOV  = 4'd5;
  localparam logic [3:0] OP_FREE  = 4'd6;
  localparam logic [3:0] OP_FREEP = 4'd7;
  localparam logic [3:0] OP_ST    = 4'd8;
  localparam logic [3:0] OP_STP   = 4'd9;
  localparam logic [3:0] OP_PUSHD = 4'd10;
  localparam logic [3:0] OP_LDCW  = 4'd11;

  localparam logic [TAG_W-1:0] TAG_VALID = 2'd0;
  localparam logic [TAG_W-1:0] TAG_ZERO  = 2'd1;
  localparam logic [TAG_W-1:0] TAG_SPEC  = 2'd2;
  localparam logic [TAG_W-1:0] TAG_EMPTY = 2'd3;

  localparam int SW_IE = 0;
  localparam int SW_SF = 6;
  localparam int SW_ES = 7;
  localparam int SW_C1 = 9;
  localparam int SW_B  = 15;
  localparam logic [15:0] CLEX_MASK = 16'h80FF;
  localparam logic [15:0] CW_INIT   = 16'h037F;

  typedef enum logic [1:0] {SRC_ST0, SRC_STI, SRC_FILL, SRC_EXT} src_e;

  typedef struct packed {
    logic             wrAEn;
    logic [IDX_W-1:0] wrAIdx;
    src_e             wrASrc;
    logic [TAG_W-1:0] wrATag;
    logic             wrBEn;
    logic [IDX_W-1:0] wrBIdx;
    src_e             wrBSrc;
    logic [TAG_W-1:0] wrBTag;
    logic             freeEn;
    logic [IDX_W-1:0] freeIdx;
    logic             pushEn;
    logic             popEn;
    logic             doInit;
    logic             doClex;
    logic             ldCw;
    logic             flagStack;
    logic             c1Val;
    logic             excUnm;
    logic             c1Clr;
  } strobe_t;

endpackage

// File: rtl/fstack_ctl.sv
module fstack_ctl
  import fstack_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [3:0]           cmdOp,
  input  logic [IDX_W-1:0]     cmdIdx,
  input  logic [2:0]           condSel,
  input  logic                 flagCf,
  input  logic                 flagZf,
  input  logic                 flagPf,
  input  logic                 extZero,
  input  logic [IDX_W-1:0]     topPtr,
  input  logic [TW_W-1:0]      tagWord,
  input  logic                 invMask,
  output strobe_t              strb,
  output logic                 done,
  output logic                 illegal,
  output logic                 stackErr,
  output logic                 excRaised
);

  function automatic logic [TAG_W-1:0] tagOf(input logic [TW_W-1:0] tw, input logic [IDX_W-1:0] p);
    return tw[{p, 1'b0} +: TAG_W];
  endfunction

  logic [IDX_W-1:0] physI, physP;
  logic [TAG_W-1:0] tag0, tagI, tagP;
  logic             condBase, condHit, badOp;
  strobe_t          s;

  assign physI = topPtr + cmdIdx;
  assign physP = topPtr - 3'd1;
  assign tag0  = tagOf(tagWord, topPtr);
  assign tagI  = tagOf(tagWord, physI);
  assign tagP  = tagOf(tagWord, physP);

  always_comb begin
    case (condSel[1:0])
      2'd0:    condBase = flagCf;
      2'd1:    condBase = flagZf;
      2'd2:    condBase = flagCf | flagZf;
      default: condBase = flagPf;
    endcase
    condHit = condBase ^ condSel[2];
  end

  always_comb begin
    s     = '0;
    badOp = 1'b0;
    if (cmdValid) begin
      case (cmdOp)
        OP_NOP:  ;
        OP_INIT: s.doInit = 1'b1;
        OP_CLEX: s.doClex = 1'b1;
        OP_LDCW: s.ldCw   = 1'b1;
        OP_LDI, OP_PUSHD: begin
          s.wrAIdx = physP;
          if (tagP != TAG_EMPTY || (cmdOp == OP_LDI && tagI == TAG_EMPTY)) begin
            s.flagStack = 1'b1;
            s.c1Val     = (tagP != TAG_EMPTY);
            s.excUnm    = !invMask;
            s.pushEn    = invMask;
            s.wrAEn     = invMask;
            s.wrASrc    = SRC_FILL;
            s.wrATag    = TAG_SPEC;
          end else begin
            s.pushEn = 1'b1;
            s.wrAEn  = 1'b1;
            s.wrASrc = (cmdOp == OP_LDI) ? SRC_STI : SRC_EXT;
            s.wrATag = (cmdOp == OP_LDI) ? tagI : (extZero ? TAG_ZERO : TAG_VALID);
          end
        end
        OP_XCH: begin
          s.wrAIdx = topPtr;
          s.wrBIdx = physI;
          if (tag0 != TAG_EMPTY && tagI != TAG_EMPTY) begin
            s.wrAEn = 1'b1; s.wrASrc = SRC_STI; s.wrATag = tagI;
            s.wrBEn = 1'b1; s.wrBSrc = SRC_ST0; s.wrBTag = tag0;
            s.c1Clr = 1'b1;
          end else begin
            s.flagStack = 1'b1;
            s.excUnm    = !invMask;
            s.wrAEn     = invMask;
            s.wrBEn     = invMask;
            if (tag0 == TAG_EMPTY && tagI != TAG_EMPTY) begin
              s.wrASrc = SRC_STI; s.wrATag = tagI;
            end else begin
              s.wrASrc = SRC_FILL; s.wrATag = TAG_SPEC;
            end
            if (tagI == TAG_EMPTY && tag0 != TAG_EMPTY) begin
              s.wrBSrc = SRC_ST0; s.wrBTag = tag0;
            end else begin
              s.wrBSrc = SRC_FILL; s.wrBTag = TAG_SPEC;
            end
          end
        end
        OP_CMOV: begin
          s.wrAIdx = topPtr;
          if (condHit) begin
            if (tagI == TAG_EMPTY) begin
              s.flagStack = 1'b1;
              s.excUnm    = !invMask;
              s.wrAEn     = invMask;
              s.wrASrc    = SRC_FILL;
              s.wrATag    = TAG_SPEC;
            end else begin
              s.wrAEn = 1'b1; s.wrASrc = SRC_STI; s.wrATag = tagI;
            end
          end
        end
        OP_FREE, OP_FREEP: begin
          s.freeEn  = 1'b1;
          s.freeIdx = physI;
          s.popEn   = (cmdOp == OP_FREEP);
        end
        OP_ST, OP_STP: begin
          s.wrBEn  = 1'b1;
          s.wrBIdx = physI;
          s.wrBSrc = SRC_ST0;
          s.wrBTag = tag0;
          s.popEn  = (cmdOp == OP_STP);
        end
        default: badOp = 1'b1;
      endcase
    end
  end

  assign strb = s;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done      <= 1'b0;
      illegal   <= 1'b0;
      stackErr  <= 1'b0;
      excRaised <= 1'b0;
    end else begin
      done      <= cmdValid;
      illegal   <= badOp;
      stackErr  <= s.flagStack;
      excRaised <= s.flagStack & s.excUnm;
    end
  end

  // R14: one-cycle completion
  p_done_next_r14: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> done);
  // R14: undefined codes flagged
  p_bad_code_r14: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp > OP_LDCW) |=> illegal);
  // R6: an exception pulse is always a stack error
  p_exc_is_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    excRaised |-> stackErr);

endmodule

// File: rtl/fstack_dp.sv
module fstack_dp
  import fstack_pkg::*;
#(
  parameter int               DATA_W   = 32,
  parameter logic [DATA_W-1:0] FILL_VAL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [DATA_W-1:0] extData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  topPtr,
  output logic [TW_W-1:0]   tagWord,
  output logic [15:0]       ctrlWord,
  output logic [15:0]       statWord
);

  logic [DATA_W-1:0] regFile [NREG];
  logic [IDX_W-1:0]  topQ, topN;
  logic [TW_W-1:0]   tagQ, tagN;
  logic [15:0]       cwQ, swQ, swN;
  logic [DATA_W-1:0] valA, valB, st0Val, stiVal;

  assign st0Val = regFile[topQ];
  assign stiVal = regFile[topQ + cmdIdx];

  function automatic logic [DATA_W-1:0] pick(input src_e sel, input logic [DATA_W-1:0] v0,
                                             input logic [DATA_W-1:0] vi, input logic [DATA_W-1:0] ve);
    case (sel)
      SRC_ST0:  return v0;
      SRC_STI:  return vi;
      SRC_FILL: return FILL_VAL;
      default:  return ve;
    endcase
  endfunction

  assign valA = pick(strb.wrASrc, st0Val, stiVal, extData);
  assign valB = pick(strb.wrBSrc, st0Val, stiVal, extData);

  always_ff @(posedge clk) begin
    if (strb.wrAEn) regFile[strb.wrAIdx] <= valA;
    if (strb.wrBEn) regFile[strb.wrBIdx] <= valB;
  end

  always_comb begin
    tagN = tagQ;
    if (strb.wrAEn)  tagN[{strb.wrAIdx, 1'b0} +: TAG_W] = strb.wrATag;
    if (strb.wrBEn)  tagN[{strb.wrBIdx, 1'b0} +: TAG_W] = strb.wrBTag;
    if (strb.freeEn) tagN[{strb.freeIdx, 1'b0} +: TAG_W] = TAG_EMPTY;
    if (strb.popEn)  tagN[{topQ, 1'b0} +: TAG_W] = TAG_EMPTY;
    if (strb.doInit) tagN = '1;

    topN = topQ;
    if (strb.pushEn)     topN = topQ - 3'd1;
    else if (strb.popEn) topN = topQ + 3'd1;
    if (strb.doInit)     topN = '0;

    swN = swQ;
    if (strb.doClex) swN = swQ & ~CLEX_MASK;
    if (strb.c1Clr)  swN[SW_C1] = 1'b0;
    if (strb.flagStack) begin
      swN[SW_IE] = 1'b1;
      swN[SW_SF] = 1'b1;
      swN[SW_C1] = strb.c1Val;
      if (strb.excUnm) begin
        swN[SW_ES] = 1'b1;
        swN[SW_B]  = 1'b1;
      end
    end
    if (strb.doInit) swN = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ <= '1;
      topQ <= '0;
      cwQ  <= CW_INIT;
      swQ  <= '0;
    end else begin
      tagQ <= tagN;
      topQ <= topN;
      swQ  <= swN;
      if (strb.doInit)    cwQ <= CW_INIT;
      else if (strb.ldCw) cwQ <= extData[15:0];
    end
  end

  assign rdData   = regFile[topQ + rdIdx];
  assign topPtr   = topQ;
  assign tagWord  = tagQ;
  assign ctrlWord = cwQ;
  assign statWord = swQ | {2'b00, topQ, 11'd0};

  // R2: push moves the top down by one
  p_push_top_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushEn |=> topQ == $past(topQ) - 3'd1);
  // R2: pop moves the top up by one
  p_pop_top_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.popEn |=> topQ == $past(topQ) + 3'd1);
  // R5: any stack fault leaves invalid and stack-fault flags set
  p_fault_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagStack |=> swQ[SW_IE] && swQ[SW_SF]);
  // R1: initialise empties everything
  p_init_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.doInit |=> tagQ == '1 && topQ == '0 && swQ == '0);

endmodule

// File: rtl/fstack_ctrl.sv
module fstack_ctrl
  import fstack_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [2:0]        cmdIdx,
  input  logic [2:0]        condSel,
  input  logic              flagCf,
  input  logic              flagZf,
  input  logic              flagPf,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [2:0]        rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        topPtr,
  output logic [15:0]       tagWord,
  output logic [15:0]       ctrlWord,
  output logic [15:0]       statWord,
  output logic              done,
  output logic              illegal,
  output logic              stackErr,
  output logic              excRaised
);

  localparam logic [DATA_W-1:0] FILL_VAL = {2'b11, {(DATA_W-2){1'b0}}};

  strobe_t strb;
  logic    extZero;

  assign extZero = (cmdData == '0);

  fstack_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx),
    .condSel(condSel), .flagCf(flagCf), .flagZf(flagZf), .flagPf(flagPf),
    .extZero(extZero), .topPtr(topPtr), .tagWord(tagWord), .invMask(ctrlWord[0]),
    .strb(strb), .done(done), .illegal(illegal), .stackErr(stackErr), .excRaised(excRaised)
  );

  fstack_dp #(.DATA_W(DATA_W), .FILL_VAL(FILL_VAL)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdIdx(cmdIdx), .extData(cmdData),
    .rdIdx(rdIdx), .rdData(rdData), .topPtr(topPtr), .tagWord(tagWord),
    .ctrlWord(ctrlWord), .statWord(statWord)
  );

  // R14: an undefined code leaves architectural state unchanged
  p_illegal_hold_r14: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> $stable(tagWord) && $stable(topPtr) && $stable(ctrlWord) && $stable(statWord));
  // R6: unmasked exception leaves top and tags alone
  p_unmasked_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    excRaised |-> $stable(tagWord) && $stable(topPtr));

endmodule

// File: tb/test_fstack_ctrl.sv
module test_fstack_ctrl;

  localparam logic [31:0] FILL = 32'hC000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdOp = '0;
  logic [2:0]  cmdIdx = '0;
  logic [2:0]  condSel = '0;
  logic        flagCf = 1'b0, flagZf = 1'b0, flagPf = 1'b0;
  logic [31:0] cmdData = '0;
  logic [2:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic [2:0]  topPtr;
  logic [15:0] tagWord, ctrlWord, statWord;
  logic        done, illegal, stackErr, excRaised;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  fstack_ctrl #(.DATA_W(32)) i_fstack_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx),
    .condSel(condSel), .flagCf(flagCf), .flagZf(flagZf), .flagPf(flagPf),
    .cmdData(cmdData), .rdIdx(rdIdx), .rdData(rdData), .topPtr(topPtr),
    .tagWord(tagWord), .ctrlWord(ctrlWord), .statWord(statWord), .done(done),
    .illegal(illegal), .stackErr(stackErr), .excRaised(excRaised)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [3:0] op, input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdIdx = idx; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic chkSt(input string req, input logic [2:0] i, input logic [31:0] exp);
    rdIdx = i;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic tReset();
    chk("R1 reset ctrl", {16'd0, ctrlWord}, 32'h037F);
    chk("R1 reset stat", {16'd0, statWord}, 32'h0);
    chk("R1 reset top", {29'd0, topPtr}, 32'd0);
    chk("R1 reset tags", {16'd0, tagWord}, 32'hFFFF);
  endtask

  task automatic tPush();
    doCmd(4'd1, 3'd0, 0);
    doCmd(4'd10, 3'd0, 32'h11);
    doCmd(4'd10, 3'd0, 32'h22);
    doCmd(4'd10, 3'd0, 32'h0);
    chk("R14 done after push", {31'd0, done}, 32'd1);
    chk("R2 top after 3 pushes", {29'd0, topPtr}, 32'd5);
    chk("R3 tags zero/valid", {16'd0, tagWord}, 32'h07FF);
    chk("R2 top in status", {16'd0, statWord}, 32'h2800);
    chkSt("R2 ST0", 3'd0, 32'h0);
    chkSt("R2 ST1", 3'd1, 32'h22);
    chkSt("R2 ST2", 3'd2, 32'h11);
  endtask

  task automatic tLoad();
    doCmd(4'd1, 3'd0, 0);
    doCmd(4'd10, 3'd0, 32'hA1);
    doCmd(4'd10, 3'd0, 32'hB2);
    doCmd(4'd3, 3'd1, 0);
    chk("R4 top", {29'd0, topPtr}, 32'd5);
    chk("R4 tags", {16'd0, tagWord}, 32'h03FF);
    chkSt("R4 ST0 copy", 3'd0, 32'hA1);
    chkSt("R4 ST1", 3'd1, 32'hB2);
    chk("R4 no error", {31'd0, stackErr}, 32'd0);
  endtask

  task automatic tLoadUnder();
    doCmd(4'd1, 3'd0, 0);
    doCmd(4'd10, 3'd0, 32'hA1);
    doCmd(4'd3, 3'd3, 0);
    chk("R7 stackErr", {31'd0, stackErr}, 32'd1);
    chk("R7 no exc", {31'd0, excRaised}, 32'd0);
    chk("R7 top", {29'd0, topPtr}, 32'd6);
    chk("R7 tags", {16'd0, tagWord}, 32'h2FFF);
    chk("R7 status", {16'd0, statWord}, 32'h3041);
    chkSt("R7 ST0 fill", 3'd0, FILL);
  endtask

  task automatic tOverflow();
    doCmd(4'd1, 3'd0, 0);
    for (int k = 1; k <= 8; k++) doCmd(4'd10, 3'd0, 32'h100 + k);
    chk("R2 full tags", {16'd0, tagWord}, 32'h0);
    doCmd(4'd10, 3'd0, 32'h999);
    chk("R5 stackErr", {31'd0, stackErr}, 32'd1);
    chk("R5 top", {29'd0, topPtr}, 32'd7);
    chk("R5 tags", {16'd0, tagWord}, 32'h8000);
    chk("R5 status C1", {16'd0, statWord}, 32'h3A41);
    chkSt("R5 ST0 fill", 3'd0, FILL);
    doCmd(4'd4, 3'd1, 0);
    chk("R8 C1 cleared", {16'd0, statWord}, 32'h3841);
    chk("R8 tags swapped", {16'd0, tagWord}, 32'h0002);
    chkSt("R8 ST0", 3'd0, 32'h108);
    chkSt("R8 ST1", 3'd1, FILL);
  endtask

  task automatic tUnmasked();
    doCmd(4'd1, 3'd0, 0);
    doCmd(4'd11, 3'd0, 32'hFFFF_037E);
    chk("R13 ldcw", {16'd0, ctrlWord}, 32'h037E);
    for (int k = 1; k <= 8; k++) doCmd(4'd10, 3'd0, 32'h100 + k);
    doCmd(4'd10, 3'd0, 32'h999);
    chk("R6 exc", {31'd0, excRaised}, 32'd1);
    chk("R6 top kept", {29'd0, topPtr}, 32'd0);
    chk("R6 tags kept", {16'd0, tagWord}, 32'h0);
    chk("R6 status", {16'd0, statWord}, 32'h82C1);
    doCmd(4'd2, 3'd0, 0);
    chk("R13 clex keeps C1", {16'd0, statWord}, 32'h0200);
    doCmd(4'd6, 3'd2, 0);
    chk("R12 free", {16'd0, tagWord}, 32'h0030);
    doCmd(4'd4, 3'd2, 0);
    chk("R9 unmasked exc", {31'd0, excRaised}, 32'd1);
    chk("R9 unmasked status", {16'd0, statWord}, 32'h80C1);
    chk("R9 tags kept", {16'd0, tagWord}, 32'h0030);
    chkSt("R9 ST0 kept", 3'd0, 32'h108);
  endtask

  task automatic tXchMasked();
    doCmd(4'd1, 3'd0, 0);
    doCmd(4'd10, 3'd0, 32'h55);
    doCmd(4'd4, 3'd1, 0);
    chk("R9 stackErr", {31'd0, stackErr}, 32'd1);
    chk("R9 tags", {16'd0, tagWord}, 32'hBFFC);
    chk("R9 status", {16'd0, statWord}, 32'h3841);
    chkSt("R9 ST1 moved", 3'd1, 32'h55);
    chkSt("R9 ST0 fill", 3'd0, FILL);
  endtask

  task automatic tCmov();
    doCmd(4'd1, 3'd0, 0);
    doCmd(4'd10, 3'd0, 32'h10);
    doCmd(4'd10, 3'd0, 32'h20);
    doCmd(4'd10, 3'd0, 32'h30);
    condSel = 3'd1; flagZf = 1'b0;
    doCmd(4'd5, 3'd2, 0);
    chkSt("R10 ZF false no move", 3'd0, 32'h30);
    condSel = 3'd5;
    doCmd(4'd5, 3'd2, 0);
    chkSt("R10 not-ZF move", 3'd0, 32'h10);
    condSel = 3'd2; flagZf = 1'b1; flagCf = 1'b0;
    doCmd(4'd5, 3'd1, 0);
    chkSt("R10 CF|ZF move", 3'd0, 32'h20);
    condSel = 3'd6;
    doCmd(4'd5, 3'd2, 0);
    chkSt("R10 not CF|ZF no move", 3'd0, 32'h20);
    condSel = 3'd3; flagPf = 1'b1;
    doCmd(4'd5, 3'd4, 0);
    chk("R11 stackErr", {31'd0, stackErr}, 32'd1);
    chkSt("R11 ST0 fill", 3'd0, FILL);
    chk("R11 tags", {16'd0, tagWord}, 32'h0BFF);
    chk("R11 status", {16'd0, statWord}, 32'h2841);
    flagPf = 1'b0; flagZf = 1'b0; condSel = 3'd0;
  endtask

  task automatic tFreeStore();
    doCmd(4'd1, 3'd0, 0);
    doCmd(4'd10, 3'd0, 32'h1);
    doCmd(4'd10, 3'd0, 32'h2);
    doCmd(4'd8, 3'd3, 0);
    chk("R12 store tags", {16'd0, tagWord}, 32'h0FF3);
    chkSt("R12 ST3", 3'd3, 32'h2);
    doCmd(4'd9, 3'd1, 0);
    chk("R12 storep top", {29'd0, topPtr}, 32'd7);
    chk("R12 storep tags", {16'd0, tagWord}, 32'h3FF3);
    chkSt("R12 storep ST0", 3'd0, 32'h2);
    doCmd(4'd6, 3'd2, 0);
    chk("R12 free tags", {16'd0, tagWord}, 32'h3FFF);
    doCmd(4'd7, 3'd0, 0);
    chk("R12 freep top", {29'd0, topPtr}, 32'd0);
    chk("R12 freep tags", {16'd0, tagWord}, 32'hFFFF);
  endtask

  task automatic tIllegal();
    doCmd(4'd1, 3'd0, 0);
    doCmd(4'd10, 3'd0, 32'h7);
    doCmd(4'd13, 3'd1, 32'h0);
    chk("R14 illegal flag", {31'd0, illegal}, 32'd1);
    chk("R14 illegal done", {31'd0, done}, 32'd1);
    chk("R14 illegal top", {29'd0, topPtr}, 32'd7);
    chk("R14 illegal tags", {16'd0, tagWord}, 32'h3FFF);
    doCmd(4'd0, 3'd0, 0);
    chk("R14 nop no illegal", {31'd0, illegal}, 32'd0);
    chk("R14 nop tags", {16'd0, tagWord}, 32'h3FFF);
    chkSt("R14 nop ST0", 3'd0, 32'h7);
    doCmd(4'd11, 3'd0, 32'h1234);
    doCmd(4'd1, 3'd0, 0);
    chk("R1 init ctrl", {16'd0, ctrlWord}, 32'h037F);
    chk("R1 init tags", {16'd0, tagWord}, 32'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPush();
    tLoad();
    tLoadUnder();
    tOverflow();
    tUnmasked();
    tXchMasked();
    tCmov();
    tFreeStore();
    tIllegal();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule